// File: doc/BRIEF.md
# Interconnect Error Address Capture Unit

This unit sits beside the address decoder of an on-chip interconnect and keeps one error record for each initiator port. When the decoder reports an illegal access from an initiator, with a single-cycle pulse and the offending address, the unit sets that initiator's sticky error flag. It also records the address. The flag stays set until software writes one to it or the chip is reset. While the flag is set the recorded address is frozen, so software always sees the first failing address of a burst of errors.

Each initiator's flag is gated by a software-controlled enable bit to form a per-initiator interrupt. A single block-level interrupt is the OR of all of them. Software reaches the flags, the enables and the captured addresses through a simple word-addressed register port. Reads are combinational, and a write takes effect at the clock edge on which `reg_wr` is high. The number of initiators and the address width are parameters. By default there are four initiators and 36-bit addresses, and each address is read back as a 32-bit low word and a 4-bit upper word.

Top module: `err_capture_top`

## Requirements
- R1: After reset every status flag, every enable bit, every captured address, `irq_init` and `irq` read as zero.
- R2: An `err_valid[i]` pulse sampled at a clock edge makes status bit i (bit i of the word at offset 0) read 1 after that edge.
- R3: When status bit i is clear, an error pulse stores its address: bits 31:0 read at offset 2+2i, and bits 35:32 read in bits 3:0 of offset 3+2i, with the upper bits zero.
- R4: While status bit i is set and not being cleared, further error pulses on initiator i leave its captured address unchanged.
- R5: Writing a word to offset 0 clears every status bit whose position holds 1 in the written data; bits written as 0 keep their value.
- R6: When a clear of bit i and an error pulse on initiator i fall in the same cycle, bit i stays set and the new address is captured.
- R7: Offset 1 holds a read/write enable mask, and `irq_init[i]` is 1 exactly when status bit i and enable bit i are both 1.
- R8: `irq` is 1 exactly when at least one bit of `irq_init` is 1.
- R9: Writes to the address offsets (2 to 2+2N-1) change nothing; the captured addresses keep their values.
- R10: Reads from offsets with no register behind them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | N_INIT | Per-initiator illegal-address pulse |
| err_addr | input | N_INIT*ADDR_W | Offending addresses, initiator i at bits [i*ADDR_W +: ADDR_W] |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_init | output | N_INIT | Per-initiator error interrupts |
| irq | output | 1 | Combined error interrupt |

## Verification
The bound checker checks these rules on every cycle for each initiator: a pulse sets the flag, a first capture copies the incoming address, a locked address stays stable, a clear that is not paired with an error drops the flag, and a clear that is paired with an error keeps the flag and takes the new address. It also checks the interrupt gating and the OR on every cycle. Only the bench scenarios show what software sees through the register port: the split of an address across two words, the zero upper bits, writes of zero and writes to read-only offsets having no effect, and zeros from unmapped offsets.

// File: rtl/err_capture_pkg.sv
package err_capture_pkg;
    localparam int DATA_W        = 32;
    localparam int OFF_STATUS    = 0;
    localparam int OFF_ENABLE    = 1;
    localparam int OFF_ADDR_BASE = 2;
endpackage

// File: rtl/err_slot.sv
module err_slot #(
    parameter int ADDR_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_v,
    input  logic [ADDR_W-1:0] err_a,
    input  logic              clr,
    output logic              sts,
    output logic [ADDR_W-1:0] addr
);
    typedef struct packed {
        logic              sts;
        logic [ADDR_W-1:0] addr;
    } slot_t;

    slot_t d, q;

    always_comb begin
        d = q;
        if (err_v && (!q.sts || clr)) begin
            d.sts  = 1'b1;
            d.addr = err_a;
        end else if (clr) begin
            d.sts = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sts  = q.sts;
    assign addr = q.addr;
endmodule

// File: rtl/err_regs.sv
module err_regs
    import err_capture_pkg::*;
#(
    parameter int N_INIT = 4,
    parameter int ADDR_W = 36,
    parameter int LO_W   = 32,
    parameter int REG_AW = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [REG_AW-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    input  logic [N_INIT-1:0]        sts,
    input  logic [N_INIT*ADDR_W-1:0] addr_flat,
    output logic [DATA_W-1:0]        reg_rdata,
    output logic [N_INIT-1:0]        en,
    output logic [N_INIT-1:0]        clr
);
    localparam int EXT_W = ADDR_W - LO_W;

    typedef struct packed {
        logic [N_INIT-1:0] en;
    } regs_t;

    regs_t d, q;

    always_comb begin
        d   = q;
        clr = '0;
        if (reg_wr) begin
            if (reg_addr == REG_AW'(OFF_STATUS)) clr  = reg_wdata[N_INIT-1:0];
            if (reg_addr == REG_AW'(OFF_ENABLE)) d.en = reg_wdata[N_INIT-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en = q.en;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(OFF_STATUS)) reg_rdata[N_INIT-1:0] = sts;
        if (reg_addr == REG_AW'(OFF_ENABLE)) reg_rdata[N_INIT-1:0] = q.en;
        for (int i = 0; i < N_INIT; i++) begin
            if (reg_addr == REG_AW'(OFF_ADDR_BASE + 2*i))
                reg_rdata[LO_W-1:0] = addr_flat[i*ADDR_W +: LO_W];
            if (reg_addr == REG_AW'(OFF_ADDR_BASE + 2*i + 1))
                reg_rdata[EXT_W-1:0] = addr_flat[i*ADDR_W+LO_W +: EXT_W];
        end
    end
endmodule

// File: rtl/err_irq_merge.sv
module err_irq_merge #(
    parameter int N_INIT = 4
) (
    input  logic [N_INIT-1:0] sts,
    input  logic [N_INIT-1:0] en,
    output logic [N_INIT-1:0] irq_init,
    output logic              irq
);
    assign irq_init = sts & en;
    assign irq      = |irq_init;
endmodule

// File: rtl/err_capture_top.sv
module err_capture_top
    import err_capture_pkg::*;
#(
    parameter int N_INIT = 4,
    parameter int ADDR_W = 36,
    parameter int LO_W   = 32,
    localparam int REG_AW = $clog2(OFF_ADDR_BASE + 2*N_INIT)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_INIT-1:0]        err_valid,
    input  logic [N_INIT*ADDR_W-1:0] err_addr,
    input  logic                     reg_wr,
    input  logic [REG_AW-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    output logic [N_INIT-1:0]        irq_init,
    output logic                     irq
);
    logic [N_INIT-1:0]        sts_vec;
    logic [N_INIT-1:0]        en_vec;
    logic [N_INIT-1:0]        clr_vec;
    logic [N_INIT*ADDR_W-1:0] addr_flat;

    for (genvar g = 0; g < N_INIT; g++) begin : g_slot
        err_slot #(.ADDR_W(ADDR_W)) slot_i (
            .clk   (clk),
            .rst_n (rst_n),
            .err_v (err_valid[g]),
            .err_a (err_addr[g*ADDR_W +: ADDR_W]),
            .clr   (clr_vec[g]),
            .sts   (sts_vec[g]),
            .addr  (addr_flat[g*ADDR_W +: ADDR_W])
        );
    end

    err_regs #(.N_INIT(N_INIT), .ADDR_W(ADDR_W), .LO_W(LO_W), .REG_AW(REG_AW)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .sts       (sts_vec),
        .addr_flat (addr_flat),
        .reg_rdata (reg_rdata),
        .en        (en_vec),
        .clr       (clr_vec)
    );

    err_irq_merge #(.N_INIT(N_INIT)) merge_i (
        .sts      (sts_vec),
        .en       (en_vec),
        .irq_init (irq_init),
        .irq      (irq)
    );
endmodule

// File: rtl/err_capture_chk.sv
module err_capture_chk
    import err_capture_pkg::*;
#(
    parameter int N_INIT = 4,
    parameter int ADDR_W = 36,
    parameter int REG_AW = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_INIT-1:0]        err_valid,
    input logic [N_INIT*ADDR_W-1:0] err_addr,
    input logic                     reg_wr,
    input logic [REG_AW-1:0]        reg_addr,
    input logic [DATA_W-1:0]        reg_wdata,
    input logic [N_INIT-1:0]        sts_vec,
    input logic [N_INIT-1:0]        en_vec,
    input logic [N_INIT*ADDR_W-1:0] addr_flat,
    input logic [N_INIT-1:0]        irq_init,
    input logic                     irq
);
    logic [N_INIT-1:0] sw_clr;
    assign sw_clr = (reg_wr && reg_addr == REG_AW'(OFF_STATUS)) ? reg_wdata[N_INIT-1:0] : '0;

    for (genvar g = 0; g < N_INIT; g++) begin : g_chk
        p_set_on_error_r2: assert property (@(posedge clk) disable iff (!rst_n)
            err_valid[g] |=> sts_vec[g]);

        p_first_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (err_valid[g] && !sts_vec[g]) |=>
            addr_flat[g*ADDR_W +: ADDR_W] == $past(err_addr[g*ADDR_W +: ADDR_W]));

        p_addr_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_vec[g] && !sw_clr[g]) |=> $stable(addr_flat[g*ADDR_W +: ADDR_W]));

        p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_clr[g] && !err_valid[g]) |=> !sts_vec[g]);

        p_clear_vs_error_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_clr[g] && err_valid[g]) |=>
            (sts_vec[g] && addr_flat[g*ADDR_W +: ADDR_W] == $past(err_addr[g*ADDR_W +: ADDR_W])));

        p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
            irq_init[g] == (sts_vec[g] && en_vec[g]));
    end

    p_irq_or_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (irq_init != '0));
endmodule

bind err_capture_top err_capture_chk #(
    .N_INIT(N_INIT), .ADDR_W(ADDR_W), .REG_AW(REG_AW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_valid (err_valid),
    .err_addr  (err_addr),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .sts_vec   (sts_vec),
    .en_vec    (en_vec),
    .addr_flat (addr_flat),
    .irq_init  (irq_init),
    .irq       (irq)
);

// File: tb/err_capture_top_tb_top.sv
module err_capture_top_tb_top;
    localparam int N  = 4;
    localparam int AW = 36;
    localparam int RA = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  err_valid = '0;
    logic [N*AW-1:0] err_addr = '0;
    logic          reg_wr = 1'b0;
    logic [RA-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [N-1:0]  irq_init;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit timed_out = 0;

    always #2.5 clk = ~clk;

    err_capture_top #(.N_INIT(N), .ADDR_W(AW), .LO_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_addr(err_addr),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_init(irq_init), .irq(irq)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = RA'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = RA'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(int i, logic [AW-1:0] a);
        @(negedge clk);
        err_valid[i] = 1'b1; err_addr[i*AW +: AW] = a;
        @(negedge clk);
        err_valid[i] = 1'b0;
    endtask

    task automatic read_addr(int i, output logic [35:0] a);
        logic [31:0] lo, hi;
        rd(2 + 2*i, lo);
        rd(3 + 2*i, hi);
        check("R3 upper word high bits zero", 64'(hi[31:4]), 64'h0);
        a = {hi[3:0], lo};
    endtask

    task automatic t_reset();
        logic [31:0] d;
        logic [35:0] a;
        rd(0, d); check("R1 status after reset", 64'(d), 64'h0);
        rd(1, d); check("R1 enable after reset", 64'(d), 64'h0);
        for (int i = 0; i < N; i++) begin
            read_addr(i, a); check("R1 address after reset", 64'(a), 64'h0);
        end
        check("R1 irq_init after reset", 64'(irq_init), 64'h0);
        check("R1 irq after reset", 64'(irq), 64'h0);
    endtask

    task automatic t_capture();
        logic [31:0] d;
        logic [35:0] a;
        pulse(1, 36'hA_1234_5678);
        rd(0, d); check("R2 status bit 1 set", 64'(d), 64'h2);
        read_addr(1, a); check("R3 captured address init1", 64'(a), 64'hA_1234_5678);
        rd(2, d); check("R3 low word separate", 64'(d), 64'h0);
    endtask

    task automatic t_lock();
        logic [35:0] a;
        pulse(1, 36'h5_DEAD_BEEF);
        pulse(1, 36'hF_FFFF_FFFF);
        read_addr(1, a); check("R4 address locked", 64'(a), 64'hA_1234_5678);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        logic [35:0] a;
        pulse(3, 36'h3_0000_0010);
        wr(0, 32'h0);
        rd(0, d); check("R5 write zero keeps bits", 64'(d), 64'hA);
        wr(0, 32'h8);
        rd(0, d); check("R5 write one clears only bit 3", 64'(d), 64'h2);
        wr(0, 32'h2);
        rd(0, d); check("R5 all cleared", 64'(d), 64'h0);
        pulse(1, 36'h7_0BAD_F00D);
        read_addr(1, a); check("R5 new capture after clear", 64'(a), 64'h7_0BAD_F00D);
    endtask

    task automatic t_simul();
        logic [31:0] d;
        logic [35:0] a;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = RA'(0); reg_wdata = 32'h2;
        err_valid[1] = 1'b1; err_addr[1*AW +: AW] = 36'h2_CAFE_0001;
        @(negedge clk);
        reg_wr = 1'b0; err_valid[1] = 1'b0;
        rd(0, d); check("R6 bit stays set", 64'(d), 64'h2);
        read_addr(1, a); check("R6 new address taken", 64'(a), 64'h2_CAFE_0001);
        wr(0, 32'hF);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        pulse(0, 36'h1_0000_0000);
        pulse(2, 36'h0_0000_0004);
        #1;
        check("R7 no irq with enables clear", 64'(irq_init), 64'h0);
        check("R8 irq low", 64'(irq), 64'h0);
        wr(1, 32'h6);
        rd(1, d); check("R7 enable readback", 64'(d), 64'h6);
        check("R7 irq_init gated", 64'(irq_init), 64'h4);
        check("R8 irq high", 64'(irq), 64'h1);
        wr(0, 32'h4);
        #1;
        check("R7 irq_init after clear", 64'(irq_init), 64'h0);
        check("R8 irq low after clear", 64'(irq), 64'h0);
        wr(1, 32'h1);
        #1;
        check("R8 irq from init0", 64'(irq), 64'h1);
    endtask

    task automatic t_readonly();
        logic [35:0] a;
        for (int o = 2; o < 2 + 2*N; o++) wr(o, 32'hFFFF_FFFF);
        read_addr(0, a); check("R9 addr init0 unchanged", 64'(a), 64'h1_0000_0000);
        read_addr(2, a); check("R9 addr init2 unchanged", 64'(a), 64'h0_0000_0004);
        read_addr(1, a); check("R9 addr init1 unchanged", 64'(a), 64'h2_CAFE_0001);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        for (int o = 2 + 2*N; o < 16; o++) begin
            rd(o, d); check("R10 unmapped reads zero", 64'(d), 64'h0);
        end
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_capture();
                t_lock();
                t_w1c();
                t_simul();
                t_irq();
                t_readonly();
                t_unmapped();
            end
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule